// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block sends bytes as asynchronous serial frames. A frame is a start bit (low), eight data bits with the least significant bit first, and a stop bit (high). Bytes enter through a byte-wide write port into a small internal queue. The engine drains the queue one frame at a time. Each bit lasts a fixed number of baud-tick enables, and the enables come from a rate generator outside the block. When nothing is being sent, the serial line rests high.

An active-low clear-to-send input gates the start of each new frame, and a separate enable input switches that gating on or off. The input passes through a two-flop synchronizer. The synchronized level is captured once per frame, at the middle of the stop bit. A high level at that point keeps the following byte in the queue. A later high level does not stop it. A frame that has started always runs to its end.

Once the line has stopped, a return of clear-to-send to low releases the next queued byte. With clear-to-send low and bytes waiting, frames follow one another with no idle time between them.

Top module: `cts_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: A frame drives `txd` with a 0 start bit, then data bits 0 to 7 with bit 0 first, then a 1 stop bit. Each bit lasts TICKS_PER_BIT (16) baud ticks, and bit positions advance only on a cycle with `baud_tick` high.
- R3: When clear-to-send permits and the queue holds a byte, the next start bit begins on the cycle right after the final tick of the previous stop bit, with no idle gap.
- R4: The flow-control decision is taken on the baud tick that completes tick 8 of the 16 in the stop bit. If the synchronized clear-to-send is high at that tick (with `auto_cts_en` at 1), the current frame completes, the line goes idle and the queued byte stays in the queue.
- R5: If clear-to-send rises only after that decision tick, the next byte is still sent back-to-back. The decision is then taken again at the stop-bit midpoint of that next frame.
- R6: A change on `cts_n` never shortens or alters a frame that has already started.
- R7: With the line idle and bytes queued, a high-to-low change on `cts_n` starts the next frame. The start bit appears 3 clock edges after `cts_n` falls.
- R8: When `auto_cts_en` is 0, `cts_n` has no effect: queued bytes go out back-to-back even with `cts_n` held high.
- R9: The queue holds FIFO_DEPTH (16) bytes. `fifo_full` is 1 when it holds 16. Writes while full are dropped. `fifo_empty` is 1 when it holds none.
- R10: `cts_n` passes through two flops before use. A fall of `cts_n` cannot start a frame earlier than the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable pulse; TICKS_PER_BIT of them make one bit time |
| wr_en | input | 1 | Write strobe for the byte queue |
| wr_data | input | 8 | Byte to queue |
| fifo_empty | output | 1 | Queue holds no byte |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH bytes |
| auto_cts_en | input | 1 | 1: clear-to-send gates new frames; 0: it is ignored |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| txd | output | 1 | Serial output, idle high |

## Verification
The assertions assume that `auto_cts_en` does not change while a frame is in flight. They also assume that `wr_en` is never applied to a full queue in a way that the design would have to record. The stimulus follows this: it changes the enable only when the line is idle and empty, and the overflow case relies on the queue's own drop rule. The assertions also take `baud_tick` to be a single-cycle enable with any spacing. The stimulus uses spacings of one and three clocks. It moves `cts_n` at chosen offsets from the stop-bit decision tick, because that placement relative to the midpoint is what separates a held byte from a sent one.

// File: rtl/cts_uart_tx.sv
module cts_uart_tx #(
  parameter int DATA_BITS     = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int FIFO_DEPTH    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 wr_en,
  input  logic [DATA_BITS-1:0] wr_data,
  output logic                 fifo_empty,
  output logic                 fifo_full,
  input  logic                 auto_cts_en,
  input  logic                 cts_n,
  output logic                 txd
);

  localparam int AW         = $clog2(FIFO_DEPTH);
  localparam int TW         = $clog2(TICKS_PER_BIT);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int MID_TICK   = TICKS_PER_BIT / 2 - 1;

  logic [DATA_BITS-1:0] mem [FIFO_DEPTH];
  logic [AW:0]          wp, rp;
  logic                 cts_m, cts_s;
  logic                 busy, hold;
  logic [BW-1:0]        bit_idx;
  logic [TW-1:0]        tick_cnt;
  logic [DATA_BITS-1:0] shreg;

  assign fifo_empty = (wp == rp);
  assign fifo_full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

  wire push      = wr_en && !fifo_full;
  wire cts_block = auto_cts_en && cts_s;
  wire last_tick = baud_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
  wire bit_end   = busy && last_tick;
  wire in_stop   = (bit_idx == BW'(FRAME_BITS - 1));
  wire in_data   = (bit_idx != '0) && !in_stop;
  wire frame_end = bit_end && in_stop;
  wire mid_stop  = busy && baud_tick && in_stop && (tick_cnt == TW'(MID_TICK));
  wire pop       = !fifo_empty && (busy ? (frame_end && !hold) : !cts_block);

  assign txd = !busy || in_stop || (in_data && shreg[0]);

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_m <= 1'b1;
      cts_s <= 1'b1;
    end else begin
      cts_m <= cts_n;
      cts_s <= cts_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      busy     <= 1'b0;
      hold     <= 1'b0;
      bit_idx  <= '0;
      tick_cnt <= '0;
      shreg    <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (mid_stop) hold <= cts_block;
      if (pop) begin
        busy     <= 1'b1;
        bit_idx  <= '0;
        tick_cnt <= '0;
        shreg    <= mem[rp[AW-1:0]];
      end else if (frame_end) begin
        busy     <= 1'b0;
        bit_idx  <= '0;
        tick_cnt <= '0;
      end else if (busy && baud_tick) begin
        if (last_tick) begin
          tick_cnt <= '0;
          bit_idx  <= bit_idx + 1'b1;
          if (in_data) shreg <= shreg >> 1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  // R6
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !frame_end |=> busy);

  // R2
  bit_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !baud_tick |=> busy && $stable(bit_idx) && $stable(tick_cnt));

  // R4
  cts_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && hold |=> !busy);

  // R3
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !hold && !fifo_empty |=> busy && bit_idx == '0 && !txd);

  // R8
  cts_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en && !busy && !fifo_empty |=> busy);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp - rp) <= (AW+1)'(FIFO_DEPTH));

  // R10
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_cts_en && !busy && !fifo_empty && cts_s |=> !busy);

endmodule

// File: tb/sim_cts_uart_tx.sv
`timescale 1ns/1ps
module sim_cts_uart_tx;
  localparam int DEPTH   = 16;
  localparam int TPB     = 16;
  localparam int FRAME_T = 10 * TPB;
  localparam int MID_POS = 9 * TPB + TPB / 2 - 1;

  logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic auto_cts_en = 1, cts_n = 1;
  logic fifo_empty, fifo_full, txd;

  cts_uart_tx u0 (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .auto_cts_en(auto_cts_en), .cts_n(cts_n), .txd(txd));

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0, tick_div = 1, tick_cnt = 0;
  bit finished = 0;
  string cur_req = "R1";

  byte unsigned m_q[$];
  byte unsigned m_cur;
  int  m_pos, presize;
  bit  m_busy, m_hold, s1 = 1, s2 = 1, blk, do_pop;

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % tick_div;
    baud_tick = (tick_cnt == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_busy = 0; m_hold = 0; m_pos = 0; s1 = 1; s2 = 1;
    end else begin
      presize = m_q.size();
      blk = auto_cts_en && s2;
      do_pop = 0;
      if (m_busy) begin
        if (baud_tick) begin
          if (m_pos == MID_POS) m_hold = blk;
          if (m_pos == FRAME_T - 1) begin
            if (!m_hold && presize > 0) do_pop = 1; else m_busy = 0;
          end else m_pos++;
        end
      end else if (presize > 0 && !blk) do_pop = 1;
      if (do_pop) begin m_cur = m_q.pop_front(); m_busy = 1; m_pos = 0; end
      if (wr_en && presize < DEPTH) m_q.push_back(wr_data);
      s2 = s1; s1 = cts_n;
    end
  end

  function automatic bit exp_txd();
    int b;
    if (!m_busy) return 1;
    b = m_pos / TPB;
    if (b == 0) return 0;
    if (b == 9) return 1;
    return m_cur[b-1];
  endfunction

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check(cur_req, txd, exp_txd());
      check("R9", fifo_empty, m_q.size() == 0);
      check("R9", fifo_full, m_q.size() == DEPTH);
    end
    if (cycles > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic wr(byte unsigned d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_pos(int p);
    for (int i = 0; i < 5000; i++) begin
      if (m_busy && m_pos == p) return;
      @(negedge clk);
    end
    check("timeout", 1'b0, 1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      if (!m_busy && m_q.size() == 0) return;
      @(negedge clk);
    end
    check("drain", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", txd, 1'b1);
    check("R1", fifo_empty, 1'b1);
    check("R1", fifo_full, 1'b0);

    // R2: frame format, ticks every third clock
    cur_req = "R2"; tick_div = 3; cts_n = 0;
    repeat (3) @(negedge clk);
    wr(8'hA5);
    wait_pos(8);             check("R2", txd, 1'b0);
    wait_pos(TPB + 8);       check("R2", txd, 1'b1);
    wait_pos(2*TPB + 8);     check("R2", txd, 1'b0);
    wait_pos(8*TPB + 8);     check("R2", txd, 1'b1);
    wait_pos(9*TPB + 8);     check("R2", txd, 1'b1);
    drain();

    // R3: back-to-back
    cur_req = "R3"; tick_div = 1;
    wr(8'h01); wr(8'h80); wr(8'h5A);
    wait_pos(FRAME_T - 1); @(negedge clk); check("R3", txd, 1'b0);
    wait_pos(FRAME_T - 1); @(negedge clk); check("R3", txd, 1'b0);
    drain();

    // R4: CTS high just before the stop-bit midpoint
    cur_req = "R4";
    wr(8'hC3); wr(8'h3C);
    wait_pos(MID_POS - 6); cts_n = 1;
    wait_pos(FRAME_T - 1);
    repeat (30) @(negedge clk);
    check("R4", txd, 1'b1);
    check("R4", fifo_empty, 1'b0);

    // R7 / R10: resume on falling CTS
    cur_req = "R7";
    cts_n = 0;
    @(negedge clk); check("R10", txd, 1'b1);
    @(negedge clk); check("R10", txd, 1'b1);
    @(negedge clk); check("R7", txd, 1'b0);
    drain();

    // R5: CTS high just after the midpoint
    cur_req = "R5";
    wr(8'h11); wr(8'h22); wr(8'h33);
    wait_pos(MID_POS + 3); cts_n = 1;
    wait_pos(FRAME_T - 1); @(negedge clk); check("R5", txd, 1'b0);
    wait_pos(FRAME_T - 1); @(negedge clk); check("R5", txd, 1'b1);
    repeat (20) @(negedge clk);
    check("R5", txd, 1'b1);
    check("R5", fifo_empty, 1'b0);
    cts_n = 0;
    drain();

    // R6: CTS toggles inside a frame
    cur_req = "R6";
    wr(8'h3C);
    wait_pos(20); cts_n = 1;
    for (int b = 2; b < 8; b++) begin
      wait_pos((b + 1) * TPB + 8);
      check("R6", txd, (8'h3C >> b) & 1);
      cts_n = ~cts_n;
    end
    wait_pos(9*TPB + 2); check("R6", txd, 1'b1);
    cts_n = 0;
    drain();

    // R8: enable low ignores CTS
    cur_req = "R8";
    auto_cts_en = 0; cts_n = 1;
    repeat (3) @(negedge clk);
    wr(8'h96); wr(8'h69);
    wait_pos(8); check("R8", txd, 1'b0);
    wait_pos(FRAME_T - 1); @(negedge clk); check("R8", txd, 1'b0);
    drain();
    auto_cts_en = 1; cts_n = 1;
    repeat (3) @(negedge clk);

    // R9: fill beyond depth while stopped
    cur_req = "R9";
    for (int i = 0; i < DEPTH + 2; i++) wr(byte'(i * 7 + 1));
    check("R9", fifo_full, 1'b1);
    check("R9", fifo_empty, 1'b0);
    cts_n = 0;
    drain();
    @(negedge clk);
    check("R9", fifo_empty, 1'b1);
    check("R1", txd, 1'b1);

    summary();
  end
endmodule